// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Top-Address Source Select

This block sits between a clocked request port and an external static RAM of 65,536 words by 24 bits that has no clock of its own. It turns each accepted request into one timed read or write on the memory pins: two chip-select lines (one active low, one active high), an active-low write strobe, an active-low output enable, a 16-bit address bus, a vector bit and a source-select pin. The source-select pin tells the memory where its top address bit comes from: the vector bit when the pin is high, address line 15 when it is low. The 24-bit data bus is tri-state at the pads and is presented here as a split output value, an output-enable and an input value.

A request carries an address, write data, a write flag and a vector-mode flag. It is taken when valid and ready are both high. Ready then stays low until the access is over. A read returns its word with a one-cycle valid pulse. The timing is set in clock counts by two parameters. WR_PULSE_CLKS is the width of the write strobe and is clamped to at least 2. RD_SAMPLE_CLKS is the number of clocks from the moment the read controls appear to the edge that captures the data. It must be at least ceil(access time / clock period) + 1. With a 5 ns clock and a 10 ns memory the defaults are 2 and 3.

Top module: `sram_vmux_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, req_ready is 1, mem_sel_n is 1, mem_sel_hi is 0, mem_wr_n is 1, mem_out_en_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: In the cycle after a read is accepted, the chip is selected (mem_sel_n 0, mem_sel_hi 1), mem_out_en_n is 0 and mem_wr_n is 1. This holds for RD_SAMPLE_CLKS cycles. mem_dq_in is captured on the edge that ends that window.
- R3: In the cycle after a write is accepted, the chip is selected and mem_wr_n is 0 for exactly WR_PULSE_CLKS cycles. mem_out_en_n stays 1 for the whole write.
- R4: mem_dq_oe is 1, with mem_dq_out equal to the write data, only from the second cycle of the write strobe through its last cycle. It falls on the same edge on which mem_wr_n rises and is 0 at every other time.
- R5: After every write the chip is deselected for exactly one cycle, with req_ready still 0, before req_ready returns to 1.
- R6: req_ready is 0 from the cycle after an acceptance until the access completes. A request presented while req_ready is 0 is ignored and causes no memory access.
- R7: Direct mode (req_vec 0): mem_top_src is 0, mem_addr equals req_addr, and mem_vec_bit is parked at 0.
- R8: Vector mode (req_vec 1): mem_top_src is 1, mem_addr bit 15 is parked at 0, mem_addr bits 14..0 equal req_addr bits 14..0, and mem_vec_bit equals req_addr bit 15. The same req_addr reaches the same memory word in either mode.
- R9: mem_addr, mem_top_src and mem_vec_bit stay stable from the first cycle of an access to its end, including the write turnaround cycle.
- R10: rsp_valid is a single-cycle pulse in the cycle after the capture edge. rsp_data holds the captured word until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vec | input | 1 | 1 = top address bit sent on the vector bit |
| req_addr | input | 16 | Word address |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 24 | Read data |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_out_en_n | output | 1 | Active-low memory output enable |
| mem_addr | output | 16 | Memory address bus |
| mem_vec_bit | output | 1 | Alternative top address bit |
| mem_top_src | output | 1 | 1 = memory uses mem_vec_bit as top bit, 0 = mem_addr[15] |
| mem_dq_out | output | 24 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 24 | Data seen on the memory bus |

## Verification
Every pin result is due a fixed number of clocks after the accepting edge. Select and strobes change one edge later. The data driver turns on two edges later and off together with the strobe release. Read data is captured RD_SAMPLE_CLKS edges after the controls appear, and rsp_valid shows in the following cycle. The bench drives requests and samples everything on the falling edge, then checks each pin in the exact cycle that count predicts, including the cycle after rsp_valid and the turnaround cycle. The memory model returns a poison word until two clocks of stable read controls have passed, so a capture one edge early is caught. It applies the source-select rule to decode the top bit, so any address mapping error shows as a data mismatch when a word written in one mode is read back in the other.

// File: rtl/sram_vmux_pkg.sv
// Package: shared state encoding for the SRAM controller sequencer.
// Assumes: one access in flight at a time.
package sram_vmux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sram_vmux_timer.sv
// Module: loadable down-counter that marks the last cycle of a timed phase.
// Assumes: load has priority; the counter rests at zero once it is exhausted.
module sram_vmux_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Counter: load on a new phase, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_vmux_seq.sv
// Module: access sequencer. Decides the phase of each access and registers
// the select, strobe, output-enable and driver-enable controls.
// Assumes: WR_CLKS >= 2 and RD_CLKS >= 1 (the top clamps them).
module sram_vmux_seq
    import sram_vmux_pkg::*;
#(
    parameter int WR_CLKS = 2,
    parameter int RD_CLKS = 3,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             idle,
    output logic             sample_stb,
    output logic             sel_act,
    output logic             wr_act,
    output logic             rd_act,
    output logic             drv_act
);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CLKS - 1);

    seq_state_t state_q, state_d;

    assign idle       = (state_q == ST_IDLE);
    assign accept     = idle && req_valid;
    assign tmr_load   = accept;
    assign tmr_val    = req_write ? WR_LOAD : RD_LOAD;
    assign sample_stb = (state_q == ST_READ) && tmr_zero;

    // Next-state: idle -> read/write -> (turn after write) -> idle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_write ? ST_WRITE : ST_READ;
            ST_READ:  if (tmr_zero)  state_d = ST_IDLE;
            ST_WRITE: if (tmr_zero)  state_d = ST_TURN;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State and pin controls, registered from the next state so pins are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_act <= 1'b0;
            wr_act  <= 1'b0;
            rd_act  <= 1'b0;
            drv_act <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_act <= (state_d == ST_READ) || (state_d == ST_WRITE);
            wr_act  <= (state_d == ST_WRITE);
            rd_act  <= (state_d == ST_READ);
            drv_act <= (state_q == ST_WRITE) && (state_d == ST_WRITE);
        end
    end

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |-> !rd_act); // R3
    AST_DRV_INSIDE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_act |-> (wr_act && sel_act)); // R4
    AST_DRV_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_act) |-> $past(wr_act)); // R4
    AST_TURN_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_act) |-> (!sel_act && !idle)); // R5
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !idle); // R6
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (rd_act && sel_act)); // R2
endmodule

// File: rtl/sram_vmux_bus.sv
// Module: address/data path. Maps the request address onto the address bus,
// the vector bit and the source-select pin, holds write data, captures reads.
// Assumes: accept and sample_stb never occur in the same cycle.
module sram_vmux_bus #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_vec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sample_stb,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_vec_bit,
    output logic              mem_top_src,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int TOP = ADDR_W - 1;

    // Address mapping: in vector mode the top bit leaves on the vector line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr    <= '0;
            mem_vec_bit <= 1'b0;
            mem_top_src <= 1'b0;
            mem_dq_out  <= '0;
        end else if (accept) begin
            mem_top_src <= req_vec;
            mem_dq_out  <= req_wdata;
            if (req_vec) begin
                mem_addr    <= {1'b0, req_addr[TOP-1:0]};
                mem_vec_bit <= req_addr[TOP];
            end else begin
                mem_addr    <= req_addr;
                mem_vec_bit <= 1'b0;
            end
        end
    end

    // Read capture: latch the bus on the sample edge and pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= sample_stb;
            if (sample_stb) rsp_data <= mem_dq_in;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_RSP_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_stb) |-> $stable(rsp_data)); // R10
endmodule

// File: rtl/sram_vmux_ctrl.sv
// Module: top of the asynchronous SRAM controller. Joins the sequencer,
// phase timer and address/data path and maps controls to pin polarities.
// Assumes: the pad ring resolves mem_dq_out/mem_dq_oe/mem_dq_in to one bus.
module sram_vmux_ctrl #(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 24,
    parameter int WR_PULSE_CLKS  = 2,
    parameter int RD_SAMPLE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_vec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_sel_n,
    output logic              mem_sel_hi,
    output logic              mem_wr_n,
    output logic              mem_out_en_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_vec_bit,
    output logic              mem_top_src,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int WR_CLKS = (WR_PULSE_CLKS < 2) ? 2 : WR_PULSE_CLKS;
    localparam int RD_CLKS = (RD_SAMPLE_CLKS < 1) ? 1 : RD_SAMPLE_CLKS;
    localparam int MAX_CLKS = (WR_CLKS > RD_CLKS) ? WR_CLKS : RD_CLKS;
    localparam int CNT_W = (MAX_CLKS < 2) ? 1 : $clog2(MAX_CLKS);

    logic             tmr_load, tmr_zero, accept, idle, sample_stb;
    logic             sel_act, wr_act, rd_act, drv_act;
    logic [CNT_W-1:0] tmr_val;

    sram_vmux_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sram_vmux_seq #(.WR_CLKS(WR_CLKS), .RD_CLKS(RD_CLKS), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .accept(accept), .idle(idle), .sample_stb(sample_stb),
        .sel_act(sel_act), .wr_act(wr_act), .rd_act(rd_act), .drv_act(drv_act)
    );

    sram_vmux_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_vec(req_vec),
        .req_addr(req_addr), .req_wdata(req_wdata), .sample_stb(sample_stb),
        .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_vec_bit(mem_vec_bit),
        .mem_top_src(mem_top_src), .mem_dq_out(mem_dq_out),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Pin polarity: both selects follow one control so they never disagree.
    assign req_ready    = idle;
    assign mem_sel_n    = ~sel_act;
    assign mem_sel_hi   = sel_act;
    assign mem_wr_n     = ~wr_act;
    assign mem_out_en_n = ~rd_act;
    assign mem_dq_oe    = drv_act;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |->
        ($stable(mem_addr) && $stable(mem_top_src) && $stable(mem_vec_bit))); // R9
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_out_en_n && $past(mem_out_en_n))); // R4
endmodule

// File: tb/sram_vmux_ctrl_tb_top.sv
`timescale 1ns/100ps
module sram_vmux_ctrl_tb_top;
    localparam int WR_CLKS = 2;
    localparam int RD_CLKS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_vec = 1'b0;
    logic [15:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [23:0] rsp_data;
    logic        mem_sel_n, mem_sel_hi, mem_wr_n, mem_out_en_n, mem_vec_bit, mem_top_src, mem_dq_oe;
    logic [15:0] mem_addr;
    logic [23:0] mem_dq_out, mem_dq_in;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_vmux_ctrl #(.WR_PULSE_CLKS(WR_CLKS), .RD_SAMPLE_CLKS(RD_CLKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_vec(req_vec), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_sel_n(mem_sel_n), .mem_sel_hi(mem_sel_hi), .mem_wr_n(mem_wr_n),
        .mem_out_en_n(mem_out_en_n), .mem_addr(mem_addr), .mem_vec_bit(mem_vec_bit),
        .mem_top_src(mem_top_src), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [23:0] mem_model [int];
    logic [23:0] exp_mem [int];
    logic        rd_prev = 1'b0, wr_prev = 1'b0, pend_ok = 1'b0;
    logic [15:0] eff_prev = '0;
    logic [23:0] pend = '0, dq_q = '0;
    int          rd_age = 0, wr_len = 0;

    wire        m_sel  = !mem_sel_n && mem_sel_hi;
    wire        m_rd   = m_sel && !mem_out_en_n && mem_wr_n;
    wire        m_wr   = m_sel && !mem_wr_n;
    wire [15:0] m_eff  = mem_top_src ? {mem_vec_bit, mem_addr[14:0]} : mem_addr;
    assign mem_dq_in = dq_q;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && (m_rd || rd_prev)) chk("R4 bus contention", 1, 0);
            if (mem_dq_oe && !m_wr)             chk("R4 drive outside strobe", 1, 0);
            if (m_wr && !mem_out_en_n)          chk("R3 output enable during write", 1, 0);
            if (m_wr) begin
                if (wr_prev && m_eff != eff_prev) chk("R9 address moved in write", {16'h0, m_eff}, {16'h0, eff_prev});
                wr_len = wr_len + 1;
                if (mem_dq_oe) begin pend = mem_dq_out; pend_ok = 1'b1; end
            end else if (wr_prev) begin
                chk("R3 strobe width", wr_len, WR_CLKS);
                chk("R4 data set up before strobe end", {31'h0, pend_ok}, 1);
                mem_model[int'(eff_prev)] = pend;
                wr_len = 0;
                pend_ok = 1'b0;
            end
            if (m_rd) begin
                rd_age = (rd_prev && m_eff == eff_prev) ? rd_age + 1 : 1;
                dq_q <= (rd_age >= 2) ? (mem_model.exists(int'(m_eff)) ? mem_model[int'(m_eff)] : 24'h0)
                                      : 24'hA5A5A5;
            end else begin
                rd_age = 0;
                dq_q <= 24'h0;
            end
            rd_prev  <= m_rd;
            wr_prev  <= m_wr;
            eff_prev <= m_eff;
        end
    end

    function automatic logic [23:0] exp_of(input logic [15:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 24'h0;
    endfunction

    function automatic logic [15:0] addr_of(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h7FFF;
            3: return 16'h8000;
            default: return 16'((i * 40503 + 7) & 16'hFFFF);
        endcase
    endfunction

    // Pin mapping check for R7/R8 in the first cycle of an access.
    task automatic chk_map(input logic [15:0] a, input logic v);
        if (v) begin
            chk("R8 source pin", {31'h0, mem_top_src}, 1);
            chk("R8 address bus", {16'h0, mem_addr}, {17'h0, a[14:0]});
            chk("R8 vector bit", {31'h0, mem_vec_bit}, {31'h0, a[15]});
        end else begin
            chk("R7 source pin", {31'h0, mem_top_src}, 0);
            chk("R7 address bus", {16'h0, mem_addr}, {16'h0, a});
            chk("R7 vector bit parked", {31'h0, mem_vec_bit}, 0);
        end
    endtask

    // Called at a falling edge with req_ready high; returns at a falling edge, idle.
    task automatic do_write(input logic [15:0] a, input logic [23:0] d, input logic v);
        req_valid = 1; req_write = 1; req_vec = v; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk("R3 pins first write cycle", {27'h0, mem_sel_n, mem_sel_hi, mem_wr_n, mem_out_en_n, mem_dq_oe}, 32'b01010);
        chk("R6 ready low when busy", {31'h0, req_ready}, 0);
        chk_map(a, v);
        for (int k = 1; k < WR_CLKS; k++) begin
            @(negedge clk);
            chk("R4 driver on late in strobe", {30'h0, mem_dq_oe, mem_wr_n}, 32'b10);
            chk("R4 write data", {8'h0, mem_dq_out}, {8'h0, d});
        end
        @(negedge clk);
        chk("R5 turnaround cycle", {27'h0, mem_sel_n, mem_sel_hi, mem_wr_n, mem_dq_oe, req_ready}, 32'b10100);
        @(negedge clk);
        chk("R5 ready after turnaround", {31'h0, req_ready}, 1);
        exp_mem[int'(a)] = d;
    endtask

    task automatic do_read(input logic [15:0] a, input logic v);
        logic [23:0] e;
        e = exp_of(a);
        req_valid = 1; req_write = 0; req_vec = v; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk("R2 pins first read cycle", {27'h0, mem_sel_n, mem_sel_hi, mem_wr_n, mem_out_en_n, mem_dq_oe}, 32'b01100);
        chk_map(a, v);
        for (int k = 1; k < RD_CLKS; k++) @(negedge clk);
        chk("R2 no early response", {30'h0, rsp_valid, mem_out_en_n}, 0);
        @(negedge clk);
        chk("R2 response valid", {31'h0, rsp_valid}, 1);
        chk("R2 read data", {8'h0, rsp_data}, {8'h0, e});
        chk("R6 ready after read", {30'h0, req_ready, mem_sel_n}, 32'b11);
        @(negedge clk);
        chk("R10 valid is one cycle", {31'h0, rsp_valid}, 0);
        chk("R10 data held", {8'h0, rsp_data}, {8'h0, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {25'h0, req_ready, mem_sel_n, mem_sel_hi, mem_wr_n, mem_out_en_n, mem_dq_oe, rsp_valid}, 32'b1101100);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {25'h0, req_ready, mem_sel_n, mem_sel_hi, mem_wr_n, mem_out_en_n, mem_dq_oe, rsp_valid}, 32'b1101100);

        // R6: a request held while busy must be ignored.
        req_valid = 1; req_write = 1; req_vec = 0; req_addr = 16'h1234; req_wdata = 24'h13579B;
        @(posedge clk); @(negedge clk);
        req_addr = 16'h4321; req_wdata = 24'hFFFFFF;
        chk("R9 address held while new request waits", {16'h0, mem_addr}, 32'h1234);
        @(negedge clk);
        chk("R9 address held in strobe", {16'h0, mem_addr}, 32'h1234);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk("R6 no access from ignored request", {30'h0, req_ready, mem_sel_n}, 32'b11);
        exp_mem[int'(16'h1234)] = 24'h13579B;
        do_read(16'h4321, 0);
        do_read(16'h1234, 1);

        // Sweep: write in one mode, read back in the other and in the same one.
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 24; i++)
                do_write(addr_of(i), 24'((addr_of(i) * 24'h1F3 + i * 24'h10101 + m * 24'h5A0000) & 24'hFFFFFF), m[0]);
            for (int i = 0; i < 24; i++) do_read(addr_of(i), ~m[0]);
            for (int i = 0; i < 4; i++)  do_read(addr_of(i), m[0]);
        end
        do_read(16'h0001, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule